// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is a purely combinational operand shifter for a 32-bit integer datapath. It takes an operand, a three-bit shift-kind code, a shift amount and the current carry flag. In the same cycle it returns the shifted value and the carry that such a shift produces. It covers:

- logical left and logical right shifts;
- arithmetic right shift;
- rotate right;
- a one-place rotate right that passes through the carry.

The amount can come from an immediate field or straight from a register. The block reads only the low byte of the amount, so a register value can be wired in without masking. Amounts of zero, of exactly the word width, and larger than the word width each follow their own rule for the result and for the carry. The block does not decode instructions, read registers or write flags. It only computes the values that the surrounding pipeline stage needs.

Top module: `operand_shifter`

## Requirements
- R1: `kind_i` selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate right through carry.
- R2: Only `amount_i[7:0]` affects the outputs. Bits 31:8 of `amount_i` have no effect for any kind.
- R3: For kinds 0 to 3 with a low-byte amount of zero, `result_o` equals `opnd_i` and `carry_o` equals `carry_i`.
- R4: For logical left with an amount n from 1 to 32, `result_o` is `opnd_i` shifted left by n with zeros filled in. `carry_o` is `opnd_i[32-n]`, the last bit pushed out of the top.
- R5: For logical left or logical right with an amount above 32, both `result_o` and `carry_o` are zero.
- R6: For logical right with an amount n from 1 to 32, `result_o` is `opnd_i` shifted right by n with zeros filled in. `carry_o` is `opnd_i[n-1]`.
- R7: For arithmetic right with an amount n from 1 to 31, the vacated top bits take `opnd_i[31]` and `carry_o` is `opnd_i[n-1]`.
- R8: For arithmetic right with an amount of 32 or more, every bit of `result_o` equals `opnd_i[31]`, and so does `carry_o`.
- R9: For rotate right with a nonzero amount, the rotate distance is the amount modulo 32. `carry_o` equals `result_o[31]`. A nonzero multiple of 32 returns the operand unchanged, with `carry_o` equal to `opnd_i[31]`.
- R10: Rotate right through carry ignores the amount. `result_o` is `{carry_i, opnd_i[31:1]}` and `carry_o` is `opnd_i[0]`.
- R11: Kind codes 5, 6 and 7 pass `opnd_i` to `result_o` and `carry_i` to `carry_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted |
| kind_i | input | 3 | Shift kind code (see R1) |
| amount_i | input | 32 | Shift amount; only the low byte is used |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Carry produced by the shift |

## Verification
The bench drives the amount boundaries 0, 1, 31, 32, 33 and 255 for each kind, and compares the outputs with a reference that moves the operand one place at a time. A design that used `>= 32` instead of `> 32` for logical shifts would lose the top or bottom operand bit as the carry at exactly 32. A design that reduced the rotate amount without treating multiples of 32 as a special case would return the incoming carry instead of bit 31. Further stimulus sets the upper amount bits to values that would change a full-width shift, runs rotate-through-carry with both carry values and several amounts, and applies the unused kind codes. These catch a mask that is missing, carries that are swapped, and an amount that leaks into the one-place rotate.

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int WIDTH    = 32,
  parameter int AMT_IN_W = 32,
  parameter int AMT_W    = 8
) (
  input  logic [WIDTH-1:0]    opnd_i,
  input  logic [2:0]          kind_i,
  input  logic [AMT_IN_W-1:0] amount_i,
  input  logic                carry_i,
  output logic [WIDTH-1:0]    result_o,
  output logic                carry_o
);

  localparam int LW = $clog2(WIDTH);
  localparam logic [AMT_W-1:0] W_AMT  = AMT_W'(WIDTH);
  localparam logic [LW:0]      W_FULL = (LW+1)'(WIDTH);

  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;

  logic [AMT_W-1:0] amt;
  logic             unused_amt_hi;
  assign amt           = amount_i[AMT_W-1:0];
  assign unused_amt_hi = ^amount_i[AMT_IN_W-1:AMT_W];

  logic                    amt_zero, amt_over, amt_full;
  assign amt_zero = (amt == '0);
  assign amt_over = (amt > W_AMT);
  assign amt_full = (amt >= W_AMT);

  logic        [WIDTH:0] lsl_w, lsr_w;
  logic signed [WIDTH:0] asr_w;
  logic [LW-1:0]         rot;
  logic [WIDTH-1:0]      ror_r;

  assign lsl_w = {1'b0, opnd_i} << amt;
  assign lsr_w = {opnd_i, 1'b0} >> amt;
  assign asr_w = $signed({opnd_i, 1'b0}) >>> amt;
  assign rot   = amt[LW-1:0];
  assign ror_r = (opnd_i >> rot) | (opnd_i << (W_FULL - {1'b0, rot}));

  always_comb begin
    result_o = opnd_i;
    carry_o  = carry_i;
    case (kind_i)
      K_LSL: if (amt_over) begin
               result_o = '0;
               carry_o  = 1'b0;
             end else if (!amt_zero) begin
               result_o = lsl_w[WIDTH-1:0];
               carry_o  = lsl_w[WIDTH];
             end
      K_LSR: if (amt_over) begin
               result_o = '0;
               carry_o  = 1'b0;
             end else if (!amt_zero) begin
               result_o = lsr_w[WIDTH:1];
               carry_o  = lsr_w[0];
             end
      K_ASR: if (amt_full) begin
               result_o = {WIDTH{opnd_i[WIDTH-1]}};
               carry_o  = opnd_i[WIDTH-1];
             end else if (!amt_zero) begin
               result_o = asr_w[WIDTH:1];
               carry_o  = asr_w[0];
             end
      K_ROR: if (!amt_zero) begin
               result_o = ror_r;
               carry_o  = ror_r[WIDTH-1];
             end
      K_RRX: begin
               result_o = {carry_i, opnd_i[WIDTH-1:1]};
               carry_o  = opnd_i[0];
             end
      default: ;
    endcase
  end

  always_comb begin
    if (kind_i <= K_ROR && amount_i[AMT_W-1:0] == '0)
      AST_ZERO_PASS: assert (result_o == opnd_i && carry_o == carry_i); // R3
    if ((kind_i == K_LSL || kind_i == K_LSR) && amount_i[AMT_W-1:0] > W_AMT)
      AST_LOGIC_FLUSH: assert (result_o == '0 && !carry_o); // R5
    if (kind_i == K_ASR && amount_i[AMT_W-1:0] >= W_AMT)
      AST_ASR_SIGN: assert (carry_o == opnd_i[WIDTH-1] && (&result_o || result_o == '0)); // R8
    if (kind_i == K_ROR && amount_i[AMT_W-1:0] != '0)
      AST_ROR_CARRY: assert (carry_o == result_o[WIDTH-1]); // R9
    if (kind_i == K_RRX)
      AST_RRX_CHAIN: assert (result_o[WIDTH-1] == carry_i && carry_o == opnd_i[0]
                             && result_o[WIDTH-2:0] == opnd_i[WIDTH-1:1]); // R10
    if (kind_i > K_RRX)
      AST_SPARE_PASS: assert (result_o == opnd_i && carry_o == carry_i); // R11
  end

endmodule

// File: tb/operand_shifter_test.sv
module operand_shifter_test;

  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] opnd;
  logic [2:0]  kind;
  logic [31:0] amount;
  logic        cin;
  logic [31:0] res;
  logic        cout;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  operand_shifter uut (
    .opnd_i(opnd), .kind_i(kind), .amount_i(amount), .carry_i(cin),
    .result_o(res), .carry_o(cout)
  );

  function automatic logic [32:0] model(input logic [2:0] k, input logic [31:0] op,
                                        input logic [31:0] a32, input logic c_in);
    logic [31:0] v;
    logic        c;
    int          n;
    v = op;
    c = c_in;
    n = int'(a32[7:0]);
    case (k)
      3'd0: for (int i = 0; i < n; i++) begin c = v[31]; v = {v[30:0], 1'b0}; end
      3'd1: for (int i = 0; i < n; i++) begin c = v[0];  v = {1'b0, v[31:1]}; end
      3'd2: for (int i = 0; i < n; i++) begin c = v[0];  v = {v[31], v[31:1]}; end
      3'd3: if (n != 0) begin
              for (int i = 0; i < n % 32; i++) v = {v[0], v[31:1]};
              c = v[31];
            end
      3'd4: begin c = v[0]; v = {c_in, v[31:1]}; end
      default: ;
    endcase
    return {c, v};
  endfunction

  task automatic apply(input logic [2:0] k, input logic [31:0] op,
                       input logic [31:0] a, input logic c);
    @(negedge clk);
    kind = k; opnd = op; amount = a; cin = c;
    #2;
  endtask

  task automatic expect_out(input string req, input logic [31:0] e_res, input logic e_c);
    n_checks++;
    if (res !== e_res || cout !== e_c) begin
      n_fail++;
      $display("FAIL %s kind=%0d op=%h amt=%h cin=%b: actual res=%h c=%b expected res=%h c=%b",
               req, kind, opnd, amount, cin, res, cout, e_res, e_c);
    end
  endtask

  task automatic check_model(input string req, input logic [2:0] k, input logic [31:0] op,
                             input logic [31:0] a, input logic c);
    logic [32:0] e;
    apply(k, op, a, c);
    e = model(k, op, a, c);
    expect_out(req, e[31:0], e[32]);
  endtask

  task automatic t_idle;
    apply(3'd0, 32'h0, 32'h0, 1'b0);
    expect_out("R3", 32'h0, 1'b0);
  endtask

  task automatic t_zero_amount;
    for (int k = 0; k < 4; k++) begin
      apply(3'(k), 32'hA5A5_0F0F, 32'h0, 1'b1);
      expect_out("R3", 32'hA5A5_0F0F, 1'b1);
      apply(3'(k), 32'h8000_0001, 32'h0, 1'b0);
      expect_out("R3", 32'h8000_0001, 1'b0);
    end
  endtask

  task automatic t_lsl;
    apply(3'd0, 32'h8000_0001, 32'd1, 1'b0);  expect_out("R4", 32'h0000_0002, 1'b1);
    apply(3'd0, 32'h0000_0001, 32'd32, 1'b0); expect_out("R4", 32'h0, 1'b1);
    apply(3'd0, 32'hFFFF_FFFF, 32'd33, 1'b1); expect_out("R5", 32'h0, 1'b0);
    apply(3'd0, 32'h1234_5678, 32'd4, 1'b0);  expect_out("R1", 32'h2345_6780, 1'b1);
  endtask

  task automatic t_lsr;
    apply(3'd1, 32'h8000_0001, 32'd1, 1'b0);  expect_out("R6", 32'h4000_0000, 1'b1);
    apply(3'd1, 32'h8000_0000, 32'd32, 1'b0); expect_out("R6", 32'h0, 1'b1);
    apply(3'd1, 32'hFFFF_FFFF, 32'd200, 1'b1); expect_out("R5", 32'h0, 1'b0);
  endtask

  task automatic t_asr;
    apply(3'd2, 32'h8000_0010, 32'd4, 1'b0);  expect_out("R7", 32'hF800_0001, 1'b0);
    apply(3'd2, 32'h4000_0008, 32'd4, 1'b0);  expect_out("R7", 32'h0400_0000, 1'b1);
    apply(3'd2, 32'h8000_0000, 32'd32, 1'b0); expect_out("R8", 32'hFFFF_FFFF, 1'b1);
    apply(3'd2, 32'h7FFF_FFFF, 32'd32, 1'b1); expect_out("R8", 32'h0, 1'b0);
    apply(3'd2, 32'h9000_0000, 32'd255, 1'b0); expect_out("R8", 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_ror;
    apply(3'd3, 32'h0000_0001, 32'd1, 1'b0);  expect_out("R9", 32'h8000_0000, 1'b1);
    apply(3'd3, 32'h1234_5678, 32'd32, 1'b1); expect_out("R9", 32'h1234_5678, 1'b0);
    apply(3'd3, 32'h8000_0000, 32'd64, 1'b0); expect_out("R9", 32'h8000_0000, 1'b1);
    apply(3'd3, 32'h0000_00F0, 32'd36, 1'b1); expect_out("R9", 32'h0000_000F, 1'b0);
  endtask

  task automatic t_rrx;
    apply(3'd4, 32'h0000_0003, 32'd0, 1'b1);  expect_out("R10", 32'h8000_0001, 1'b1);
    apply(3'd4, 32'h0000_0002, 32'd17, 1'b0); expect_out("R10", 32'h0000_0001, 1'b0);
    apply(3'd4, 32'hFFFF_FFFE, 32'd255, 1'b0); expect_out("R10", 32'h7FFF_FFFF, 1'b0);
  endtask

  task automatic t_high_bits;
    apply(3'd0, 32'h0000_00FF, 32'hFFFF_FF04, 1'b0); expect_out("R2", 32'h0000_0FF0, 1'b0);
    apply(3'd1, 32'hF000_0000, 32'h0000_0100, 1'b1); expect_out("R2", 32'hF000_0000, 1'b1);
    apply(3'd3, 32'h0000_0001, 32'h1234_5601, 1'b0); expect_out("R2", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_spare_codes;
    for (int k = 5; k < 8; k++) begin
      apply(3'(k), 32'hDEAD_BEEF, 32'd7, 1'b1);
      expect_out("R11", 32'hDEAD_BEEF, 1'b1);
    end
  endtask

  task automatic t_sweep;
    logic [31:0] ops [3];
    ops[0] = 32'h8000_0001; ops[1] = 32'h5A3C_96E1; ops[2] = 32'hC000_0002;
    for (int k = 0; k < 5; k++)
      for (int oi = 0; oi < 3; oi++) begin
        for (int a = 0; a <= 40; a++)
          check_model("R1", 3'(k), ops[oi], 32'(a), 1'(oi));
        check_model("R1", 3'(k), ops[oi], 32'd63, 1'b1);
        check_model("R1", 3'(k), ops[oi], 32'd64, 1'b0);
        check_model("R1", 3'(k), ops[oi], 32'd255, 1'b1);
      end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    opnd = '0; kind = '0; amount = '0; cin = 1'b0;
    t_idle();
    t_zero_amount();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_rrx();
    t_high_bits();
    t_spare_codes();
    t_sweep();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL all requirements: actual run still busy, expected completion");
      summary();
      $finish;
    end
  end

endmodule